// File: doc/BRIEF.md
# LED Software Override Unit

This block sits between a port status controller and the LED pins of a repeater-style device. Normally it passes the active-low LED vectors of two banks straight through. Each bank has a set of per-port LEDs and one global LED. A management interface can take over either bank and force its LEDs to follow a common override waveform. The waveform can be dark, blinking slowly, blinking more slowly, or lit solid.

Override takes two steps. A rate command first chooses the waveform. An enable command then names the banks to take over. Only one rate register exists, so every bank under override follows the rate written most recently. This includes a bank that was enabled before the rate changed. A disable command hands a bank back to the status controller. Blink timing counts a one-millisecond tick input. The half periods are parameters, so both blink rates can be scaled.

Top module: `led_override_unit`

## Requirements
- R1: After reset the rate code is 00 and neither bank is overridden. Both banks pass their normal vectors through.
- R2: Command opcode 01 with arg bit 0 set places bank A under override. All NPORT bank A port LEDs and the bank A global LED then follow the override level. A low output means lit.
- R3: Opcode 01 with arg bit 1 set does the same for bank B, covering its port LEDs and its global LED.
- R4: Opcode 00 stores arg as the rate code. Code 00 drives overridden LEDs high (dark). Code 11 drives them low (lit solid).
- R5: Rate code 01 blinks with a 50% duty cycle. Each phase lasts SLOW_HALF_MS millisecond ticks.
- R6: Rate code 10 blinks with a 50% duty cycle. Each phase lasts VSLOW_HALF_MS millisecond ticks.
- R7: Writing a rate restarts the waveform in its lit phase with the tick count at zero. This takes effect from the cycle after the command, and a tick in the same cycle is not counted.
- R8: All overridden banks follow the most recently written rate, including banks enabled before that write.
- R9: Opcode 10 with arg bit 0 and/or bit 1 set returns bank A and/or bank B to normal display.
- R10: A bank that is not overridden shows its normal vector in the same cycle, with no register on the path.
- R11: Opcode 11 is ignored. The rate, the waveform phase and both bank enables are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | Opcode: 00 rate, 01 enable, 10 disable, 11 none |
| cmd_arg | input | 2 | Rate code, or bank select (bit 0 A, bit 1 B) |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| norm_a_n | input | NPORT | Normal bank A port LEDs, active low |
| norm_ga_n | input | 1 | Normal bank A global LED, active low |
| norm_b_n | input | NPORT | Normal bank B port LEDs, active low |
| norm_gb_n | input | 1 | Normal bank B global LED, active low |
| led_a_n | output | NPORT | Final bank A port LEDs, active low |
| led_ga_n | output | 1 | Final bank A global LED, active low |
| led_b_n | output | NPORT | Final bank B port LEDs, active low |
| led_gb_n | output | 1 | Final bank B global LED, active low |

## Verification
The bench builds the block with NPORT at its default of 5, SLOW_HALF_MS at 3 and VSLOW_HALF_MS at 5. The real half periods need hundreds of ticks. With these short values, many full blink periods of both rates fit into a short run. So does a rate rewrite in the middle of a phase, and a tick that lands in the same cycle as a rate command. Random commands, ticks and normal vectors are mixed with directed sequences. This covers banks enabled in either order and rates changed while both banks are held.

// File: rtl/led_override_unit.sv
module led_override_unit #(
  parameter int NPORT         = 5,
  parameter int SLOW_HALF_MS  = 256,
  parameter int VSLOW_HALF_MS = 780
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [1:0]       cmd_arg,
  input  logic             ms_tick,
  input  logic [NPORT-1:0] norm_a_n,
  input  logic             norm_ga_n,
  input  logic [NPORT-1:0] norm_b_n,
  input  logic             norm_gb_n,
  output logic [NPORT-1:0] led_a_n,
  output logic             led_ga_n,
  output logic [NPORT-1:0] led_b_n,
  output logic             led_gb_n
);
  localparam int MAXH = (SLOW_HALF_MS > VSLOW_HALF_MS) ? SLOW_HALF_MS : VSLOW_HALF_MS;
  localparam int CW   = $clog2(MAXH + 1);
  localparam logic [CW-1:0] SLOW_LAST  = CW'(SLOW_HALF_MS - 1);
  localparam logic [CW-1:0] VSLOW_LAST = CW'(VSLOW_HALF_MS - 1);

  logic [1:0]    rate;
  logic          phase;
  logic [CW-1:0] cnt;
  logic          ovr_a, ovr_b;

  wire set_rate = cmd_valid && cmd_op == 2'b00;
  wire set_ovr  = cmd_valid && cmd_op == 2'b01;
  wire clr_ovr  = cmd_valid && cmd_op == 2'b10;
  wire blinking = rate == 2'b01 || rate == 2'b10;
  wire [CW-1:0] last = (rate == 2'b01) ? SLOW_LAST : VSLOW_LAST;
  wire lit = (rate == 2'b11) || (blinking && phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate  <= 2'b00;
      phase <= 1'b1;
      cnt   <= '0;
    end else if (set_rate) begin
      rate  <= cmd_arg;
      phase <= 1'b1;
      cnt   <= '0;
    end else if (ms_tick && blinking) begin
      if (cnt == last) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_a <= 1'b0;
      ovr_b <= 1'b0;
    end else if (set_ovr) begin
      ovr_a <= ovr_a | cmd_arg[0];
      ovr_b <= ovr_b | cmd_arg[1];
    end else if (clr_ovr) begin
      ovr_a <= ovr_a & ~cmd_arg[0];
      ovr_b <= ovr_b & ~cmd_arg[1];
    end
  end

  assign led_a_n  = ovr_a ? {NPORT{~lit}} : norm_a_n;
  assign led_ga_n = ovr_a ? ~lit : norm_ga_n;
  assign led_b_n  = ovr_b ? {NPORT{~lit}} : norm_b_n;
  assign led_gb_n = ovr_b ? ~lit : norm_gb_n;

  // R7
  rate_restart_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_rate |=> phase && cnt == '0);
  // R11
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_rate |=> $stable(rate));
  // R5
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ms_tick && !cmd_valid) |=> $stable(phase) && $stable(cnt));
  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(MAXH));
  // R9
  disable_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr && cmd_arg[0]) |=> !ovr_a);
  // R2
  solid_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ovr && cmd_arg[0] && rate == 2'b11) |=> led_a_n == '0 && !led_ga_n);
endmodule

// File: tb/led_override_unit_tb.sv
`timescale 1ns/1ps
module led_override_unit_tb;
  localparam int NP = 5, SH = 3, VH = 5;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, ms_tick = 0;
  logic [1:0] cmd_op = 0, cmd_arg = 0;
  logic [NP-1:0] norm_a_n = '1, norm_b_n = '1;
  logic norm_ga_n = 1, norm_gb_n = 1;
  logic [NP-1:0] led_a_n, led_b_n;
  logic led_ga_n, led_gb_n;

  int checks = 0, errors = 0;
  logic [1:0] m_rate = 0;
  logic m_ph = 1, m_a = 0, m_b = 0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  led_override_unit #(.NPORT(NP), .SLOW_HALF_MS(SH), .VSLOW_HALF_MS(VH)) u_dut (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_arg, .ms_tick,
    .norm_a_n, .norm_ga_n, .norm_b_n, .norm_gb_n,
    .led_a_n, .led_ga_n, .led_b_n, .led_gb_n);

  function automatic logic m_lit();
    return m_rate == 2'b11 || ((m_rate == 2'b01 || m_rate == 2'b10) && m_ph);
  endfunction

  function automatic logic [2*NP+1:0] expect_out();
    logic [NP:0] a, b;
    a = m_a ? {(NP+1){~m_lit()}} : {norm_a_n, norm_ga_n};
    b = m_b ? {(NP+1){~m_lit()}} : {norm_b_n, norm_gb_n};
    return {a, b};
  endfunction

  task automatic check(string tag);
    logic [2*NP+1:0] act, exp;
    act = {led_a_n, led_ga_n, led_b_n, led_gb_n};
    exp = expect_out();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, logic v, logic [1:0] op, logic [1:0] arg, logic t, logic rnd);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_arg = arg; ms_tick = t;
    if (rnd) begin
      norm_a_n = NP'($urandom); norm_b_n = NP'($urandom);
      norm_ga_n = 1'($urandom); norm_gb_n = 1'($urandom);
    end
    #2 check(tag);
    @(posedge clk);
    if (v && op == 2'b00) begin
      m_rate = arg; m_ph = 1; m_cnt = 0;
    end else if (t && (m_rate == 2'b01 || m_rate == 2'b10)) begin
      if (m_cnt == ((m_rate == 2'b01) ? SH : VH) - 1) begin m_cnt = 0; m_ph = ~m_ph; end
      else m_cnt++;
    end
    if (v && op == 2'b01) begin m_a = m_a | arg[0]; m_b = m_b | arg[1]; end
    if (v && op == 2'b10) begin m_a = m_a & ~arg[0]; m_b = m_b & ~arg[1]; end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 4; i++) cyc("R1", 0, 0, 0, i[0], 1);
    for (int i = 0; i < 4; i++) cyc("R10", 0, 0, 0, 0, 1);
    cyc("R4", 1, 2'b00, 2'b11, 0, 1);
    cyc("R2", 1, 2'b01, 2'b01, 0, 1);
    for (int i = 0; i < 3; i++) cyc("R2", 0, 0, 0, 1, 1);
    cyc("R4", 1, 2'b00, 2'b00, 0, 1);
    cyc("R4", 0, 0, 0, 1, 1);
    cyc("R3", 1, 2'b01, 2'b10, 0, 1);
    cyc("R5", 1, 2'b00, 2'b01, 0, 1);
    for (int i = 0; i < 14; i++) cyc("R5", 0, 0, 0, (i % 2 == 0), 1);
    cyc("R7", 1, 2'b00, 2'b10, 1, 1);
    for (int i = 0; i < 24; i++) cyc("R6", 0, 0, 0, 1, 1);
    cyc("R11", 1, 2'b11, 2'b11, 0, 1);
    for (int i = 0; i < 3; i++) cyc("R11", 0, 0, 0, 1, 1);
    cyc("R7", 1, 2'b00, 2'b01, 0, 1);
    cyc("R8", 0, 0, 0, 1, 1);
    cyc("R8", 1, 2'b00, 2'b11, 0, 1);
    cyc("R8", 0, 0, 0, 0, 1);
    cyc("R9", 1, 2'b10, 2'b01, 0, 1);
    for (int i = 0; i < 3; i++) cyc("R9", 0, 0, 0, 1, 1);
    cyc("R9", 1, 2'b10, 2'b10, 0, 1);
    cyc("R10", 0, 0, 0, 0, 1);
    for (int i = 0; i < 3000; i++) begin
      logic v;
      v = ($urandom % 8) == 0;
      cyc("R8", v, 2'($urandom), 2'($urandom), ($urandom % 2) == 0, 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule